// File: doc/BRIEF.md
# Shared SRAM Time-Multiplexed Arbiter

This block lets a group of compute units share one external static RAM, one unit at a time. A unit that wants the memory raises its request line and waits. When the memory is free, the arbiter grants exactly one requester, picked by a pointer that walks the units in a fixed cyclic order. The granted unit signals that it holds the memory by raising its own copy of a shared occupancy flag. It then performs its reads and writes over a 20-bit address and 16-bit data port and lowers the flag when it is done. Lowering the flag ends the grant.

Only the holder's address, write data and write strobe reach the memory. Every other unit's bus-drive enable is forced off, so a unit with nothing to do cannot disturb the bus. A small synchronous memory model is included so that writes and read-back can be observed at the ports. The memory uses one-cycle writes and registered reads, and it decodes only the low address bits.

Top module: `sram_share_arbiter`

## Requirements
- R1: While reset is high, and in the first cycle after it, no grant is active, the occupancy output is low and the memory enable is low. Reset returns the turn pointer to unit 0, so the first search starts at unit 0.
- R2: At most one grant bit is high at any time. A grant is only issued to a unit whose request was high at the issuing clock edge. With no requests, no grant appears.
- R3: While a grant is active, no other unit is granted, and the grant bit does not move.
- R4: A grant goes to the first requesting unit found by searching upward from the turn pointer and wrapping from unit 7 to unit 0. After a grant, the pointer moves to the unit after the one granted. This means a unit that requests again right away is served only after every other pending unit.
- R5: A request seen at a clock edge while the arbiter is idle produces the grant in the cycle that follows that edge.
- R6: A grant stays active until the holder's flag has gone high and then been seen low at a clock edge; there is no timeout. The grant drops at that edge.
- R7: No new grant is issued at the edge where the holder's release is seen. The earliest next grant comes one cycle later.
- R8: The occupancy output follows only the current holder's flag input and is low when no unit holds a grant. Flag inputs from other units are ignored.
- R9: The memory address, write data and write strobe come only from the holder. The memory enable is high only when the holder asserts its drive line.
- R10: The drive-enable output for unit i is high only when unit i holds the grant and asserts its drive line. All other units' drive enables are low. The holder's own drive enable falls in the same cycle as its drive line.
- R11: A write takes effect at the clock edge where it is presented. A read presented at an edge returns the stored word on the read-data output during the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cu_req | input | NUM_CU | Access request per unit |
| cu_flag | input | NUM_CU | Each unit's drive of the occupancy flag |
| cu_drive | input | NUM_CU | Unit wants to drive the memory bus |
| cu_we | input | NUM_CU | Write strobe per unit (1 = write, 0 = read) |
| cu_addr | input | NUM_CU*20 | Addresses, unit i in bits [i*20 +: 20] |
| cu_wdata | input | NUM_CU*16 | Write data, unit i in bits [i*16 +: 16] |
| cu_gnt | output | NUM_CU | One-hot grant |
| cu_drive_en | output | NUM_CU | Permitted bus drive per unit |
| occ_flag | output | 1 | Shared occupancy flag seen by all units |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 20 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | output | 16 | Registered read data, broadcast to all units |

## Verification
Several properties are checked by assertions on every cycle:
- the grant is one-hot or empty;
- a new grant is always backed by a request;
- a held grant neither moves nor overlaps another grant, and it falls as soon as the holder's flag is seen low;
- drive enables and the memory enable never appear without a grant, and the occupancy output is never high without one.

Other properties can only be shown by the bench's scenarios:
- the cyclic turn order over many request patterns, including re-requests, wrap-around and a pointer reset;
- the exact grant latency and the idle cycle after a release;
- that noise driven by non-holders (their flags, strobes and addresses) never reaches the memory;
- that data written by a holder reads back intact.

// File: rtl/sram_arb_pkg.sv
package sram_arb_pkg;

    localparam int unsigned ADDR_W = 20;
    localparam int unsigned DATA_W = 16;

    typedef enum logic [1:0] {
        ARB_IDLE     = 2'd0,
        ARB_WAIT_SET = 2'd1,
        ARB_OWNED    = 2'd2
    } arb_state_e;

    typedef struct packed {
        logic              en;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } mem_cmd_t;

    function automatic int unsigned wrap_index(input int unsigned v, input int unsigned n);
        return (v >= n) ? v - n : v;
    endfunction

endpackage

// File: rtl/sram_arb_picker.sv
module sram_arb_picker
    import sram_arb_pkg::*;
#(
    parameter int unsigned NUM_CU = 8,
    localparam int unsigned IW = (NUM_CU > 1) ? $clog2(NUM_CU) : 1
) (
    input  logic [NUM_CU-1:0] req,
    input  logic [IW-1:0]     ptr,
    output logic              found,
    output logic [IW-1:0]     pick
);
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = 0; k < int'(NUM_CU); k++) begin
            int unsigned s;
            s = wrap_index(int'(ptr) + k, NUM_CU);
            if (!found && req[s]) begin
                found = 1'b1;
                pick  = s[IW-1:0];
            end
        end
    end
endmodule

// File: rtl/sram_arb_ctrl.sv
module sram_arb_ctrl
    import sram_arb_pkg::*;
#(
    parameter int unsigned NUM_CU = 8,
    localparam int unsigned IW = (NUM_CU > 1) ? $clog2(NUM_CU) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CU-1:0] req,
    input  logic [NUM_CU-1:0] flag_in,
    output logic [NUM_CU-1:0] gnt,
    output logic [IW-1:0]     holder,
    output logic              active,
    output logic              occ
);
    arb_state_e    state;
    logic [IW-1:0] ptr;
    logic          pick_found;
    logic [IW-1:0] pick_idx;
    logic          hold_flag;

    sram_arb_picker #(.NUM_CU(NUM_CU)) u_pick (
        .req   (req),
        .ptr   (ptr),
        .found (pick_found),
        .pick  (pick_idx)
    );

    assign active    = (state != ARB_IDLE);
    assign hold_flag = flag_in[holder];
    assign occ       = active && hold_flag;

    for (genvar i = 0; i < NUM_CU; i++) begin : g_gnt
        assign gnt[i] = active && (holder == IW'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ARB_IDLE;
            ptr    <= '0;
            holder <= '0;
        end else begin
            case (state)
                ARB_IDLE: begin
                    if (pick_found) begin
                        holder <= pick_idx;
                        ptr    <= (pick_idx == IW'(NUM_CU-1)) ? '0 : pick_idx + 1'b1;
                        state  <= ARB_WAIT_SET;
                    end
                end
                ARB_WAIT_SET: if (hold_flag)  state <= ARB_OWNED;
                ARB_OWNED:    if (!hold_flag) state <= ARB_IDLE;
                default:      state <= ARB_IDLE;
            endcase
        end
    end

    assert_gnt_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    assert_gnt_requested_R2: assert property (@(posedge clk) disable iff (rst)
        ((|gnt) && !$past(|gnt)) |-> (|(gnt & $past(req))));

    // R3 and R7: a held grant stays put or falls to empty, never jumps to another unit
    assert_grant_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (|gnt) |=> ((gnt == $past(gnt)) || (gnt == '0)));

    assert_release_drop_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ARB_OWNED && !hold_flag) |=> (gnt == '0));

endmodule

// File: rtl/sram_arb_mux.sv
module sram_arb_mux
    import sram_arb_pkg::*;
#(
    parameter int unsigned NUM_CU = 8,
    localparam int unsigned IW = (NUM_CU > 1) ? $clog2(NUM_CU) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CU-1:0]        gnt,
    input  logic [IW-1:0]            holder,
    input  logic                     active,
    input  logic [NUM_CU-1:0]        cu_drive,
    input  logic [NUM_CU-1:0]        cu_we,
    input  logic [NUM_CU*ADDR_W-1:0] cu_addr,
    input  logic [NUM_CU*DATA_W-1:0] cu_wdata,
    output logic [NUM_CU-1:0]        drive_en,
    output mem_cmd_t                 cmd
);
    logic [ADDR_W-1:0] addr_sel [NUM_CU];
    logic [DATA_W-1:0] data_sel [NUM_CU];

    for (genvar i = 0; i < NUM_CU; i++) begin : g_lane
        assign drive_en[i] = gnt[i] & cu_drive[i];
        assign addr_sel[i] = cu_addr[i*ADDR_W +: ADDR_W];
        assign data_sel[i] = cu_wdata[i*DATA_W +: DATA_W];
    end

    always_comb begin
        cmd.en    = active && cu_drive[holder];
        cmd.we    = cmd.en && cu_we[holder];
        cmd.addr  = active ? addr_sel[holder] : '0;
        cmd.wdata = active ? data_sel[holder] : '0;
    end

    assert_drive_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drive_en));

    assert_drive_granted_R10: assert property (@(posedge clk) disable iff (rst)
        (drive_en & ~gnt) == '0);

    assert_mem_needs_grant_R9: assert property (@(posedge clk) disable iff (rst)
        cmd.en |-> (|gnt));

endmodule

// File: rtl/sram_arb_mem.sv
module sram_arb_mem
    import sram_arb_pkg::*;
#(
    parameter int unsigned DEPTH_LOG2 = 6,
    localparam int unsigned DEPTH = 1 << DEPTH_LOG2
) (
    input  logic              clk,
    input  logic              rst,
    input  mem_cmd_t          cmd,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store [DEPTH];
    logic [DEPTH_LOG2-1:0] idx;

    assign idx = cmd.addr[DEPTH_LOG2-1:0];

    always_ff @(posedge clk) begin
        if (cmd.en && cmd.we) store[idx] <= cmd.wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)                     rdata <= '0;
        else if (cmd.en && !cmd.we)  rdata <= store[idx];
    end

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !(cmd.en && !cmd.we) |=> $stable(rdata));

endmodule

// File: rtl/sram_share_arbiter.sv
module sram_share_arbiter
    import sram_arb_pkg::*;
#(
    parameter int unsigned NUM_CU = 8,
    parameter int unsigned MEM_DEPTH_LOG2 = 6,
    localparam int unsigned IW = (NUM_CU > 1) ? $clog2(NUM_CU) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CU-1:0]        cu_req,
    input  logic [NUM_CU-1:0]        cu_flag,
    input  logic [NUM_CU-1:0]        cu_drive,
    input  logic [NUM_CU-1:0]        cu_we,
    input  logic [NUM_CU*ADDR_W-1:0] cu_addr,
    input  logic [NUM_CU*DATA_W-1:0] cu_wdata,
    output logic [NUM_CU-1:0]        cu_gnt,
    output logic [NUM_CU-1:0]        cu_drive_en,
    output logic                     occ_flag,
    output logic                     mem_en,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [DATA_W-1:0]        mem_wdata,
    output logic [DATA_W-1:0]        mem_rdata
);
    logic [IW-1:0] holder;
    logic          active;
    mem_cmd_t      cmd;

    sram_arb_ctrl #(.NUM_CU(NUM_CU)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .req     (cu_req),
        .flag_in (cu_flag),
        .gnt     (cu_gnt),
        .holder  (holder),
        .active  (active),
        .occ     (occ_flag)
    );

    sram_arb_mux #(.NUM_CU(NUM_CU)) u_mux (
        .clk      (clk),
        .rst      (rst),
        .gnt      (cu_gnt),
        .holder   (holder),
        .active   (active),
        .cu_drive (cu_drive),
        .cu_we    (cu_we),
        .cu_addr  (cu_addr),
        .cu_wdata (cu_wdata),
        .drive_en (cu_drive_en),
        .cmd      (cmd)
    );

    sram_arb_mem #(.DEPTH_LOG2(MEM_DEPTH_LOG2)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .rdata (mem_rdata)
    );

    assign mem_en    = cmd.en;
    assign mem_we    = cmd.we;
    assign mem_addr  = cmd.addr;
    assign mem_wdata = cmd.wdata;

    assert_occ_needs_grant_R8: assert property (@(posedge clk) disable iff (rst)
        occ_flag |-> (|cu_gnt));

endmodule

// File: tb/sim_sram_share_arbiter.sv
module sim_sram_share_arbiter;
    localparam int N  = 8;
    localparam int AW = 20;
    localparam int DW = 16;

    logic            clk = 1'b0;
    logic            rst;
    logic [N-1:0]    cu_req, cu_flag, cu_drive, cu_we;
    logic [N*AW-1:0] cu_addr;
    logic [N*DW-1:0] cu_wdata;
    logic [N-1:0]    cu_gnt, cu_drive_en;
    logic            occ_flag, mem_en, mem_we;
    logic [AW-1:0]   mem_addr;
    logic [DW-1:0]   mem_wdata, mem_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sram_share_arbiter #(.NUM_CU(N), .MEM_DEPTH_LOG2(6)) u0 (
        .clk(clk), .rst(rst), .cu_req(cu_req), .cu_flag(cu_flag),
        .cu_drive(cu_drive), .cu_we(cu_we), .cu_addr(cu_addr), .cu_wdata(cu_wdata),
        .cu_gnt(cu_gnt), .cu_drive_en(cu_drive_en), .occ_flag(occ_flag),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // {request mask, expected grantee}; pointer starts at 0 after reset
    localparam logic [10:0] VEC [10] = '{
        {8'b0000_0001, 3'd0}, {8'b0000_0001, 3'd0}, {8'b1000_0011, 3'd1},
        {8'b1000_0011, 3'd7}, {8'b1000_0011, 3'd0}, {8'b0011_0000, 3'd4},
        {8'b0011_0000, 3'd5}, {8'b0100_0100, 3'd6}, {8'b0100_0100, 3'd2},
        {8'b1111_1111, 3'd3}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_unit(input int i, input logic drv, input logic we,
                            input logic [AW-1:0] a, input logic [DW-1:0] d);
        cu_drive[i] = drv;
        cu_we[i]    = we;
        cu_addr[i*AW +: AW]  = a;
        cu_wdata[i*DW +: DW] = d;
    endtask

    task automatic next_neg();
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        cu_req = '0; cu_flag = '0; cu_drive = '0; cu_we = '0;
        cu_addr = '0; cu_wdata = '0;
        repeat (3) @(posedge clk);
        next_neg();
        check(cu_gnt == '0 && !occ_flag && !mem_en, "R1 reset state",
              {cu_gnt, 7'd0, occ_flag, mem_en}, 0);
        rst = 1'b0;

        // R2: no requests, no grant
        repeat (4) next_neg();
        check(cu_gnt == '0, "R2 no request no grant", cu_gnt, 0);

        for (int e = 0; e < 10; e++) begin
            logic [N-1:0] mask;
            int           g;
            mask = VEC[e][10:3];
            g    = int'(VEC[e][2:0]);
            cu_req = mask;
            cu_flag = '0;
            for (int i = 0; i < N; i++) set_unit(i, 1'b1, 1'b0, AW'(100 + i), 16'hDEAD);
            next_neg();
            check(cu_gnt == N'(1 << g), "R4 R5 cyclic grant", cu_gnt, N'(1 << g));
            check(mem_addr == AW'(100 + g) && cu_drive_en == N'(1 << g),
                  "R9 R10 only holder drives", {mem_addr, cu_drive_en}, {AW'(100 + g), N'(1 << g)});
            cu_flag = ~N'(1 << g);
            #1;
            check(!occ_flag, "R8 others' flags ignored", occ_flag, 0);
            cu_flag = '1;
            for (int i = 0; i < N; i++)
                if (i != g) set_unit(i, 1'b1, 1'b1, AW'(e), 16'hBAD0);
            set_unit(g, 1'b1, 1'b1, AW'(e), DW'(16'hA000 + e));
            next_neg();
            check(occ_flag && mem_we && mem_wdata == DW'(16'hA000 + e), "R8 R9 holder write",
                  {occ_flag, mem_we, mem_wdata}, {2'b11, DW'(16'hA000 + e)});
            set_unit(g, 1'b1, 1'b0, AW'(e), '0);
            next_neg();
            check(mem_rdata == DW'(16'hA000 + e), "R11 read back", mem_rdata, DW'(16'hA000 + e));
            check(cu_gnt == N'(1 << g), "R6 grant held", cu_gnt, N'(1 << g));
            cu_flag[g] = 1'b0;
            set_unit(g, 1'b0, 1'b0, '0, '0);
            #1;
            check(cu_drive_en == '0 && !mem_en, "R10 release drops drive",
                  {cu_drive_en, mem_en}, 0);
            next_neg();
            check(cu_gnt == '0 && !occ_flag, "R7 no grant at release edge",
                  {cu_gnt, occ_flag}, 0);
            cu_flag = '0;
            for (int i = 0; i < N; i++) set_unit(i, 1'b0, 1'b0, '0, '0);
        end

        // pointer now at 4; R6 no timeout with unit 3 waiting
        cu_req = 8'h09;
        next_neg();
        check(cu_gnt == 8'h01, "R4 wrap to unit 0", cu_gnt, 8'h01);
        repeat (40) next_neg();
        check(cu_gnt == 8'h01, "R6 no timeout before flag set", cu_gnt, 8'h01);
        cu_flag[0] = 1'b1;
        repeat (30) next_neg();
        check(cu_gnt == 8'h01 && occ_flag, "R3 R6 held while flag high",
              {cu_gnt, occ_flag}, {8'h01, 1'b1});
        cu_flag[0] = 1'b0;
        cu_req[0]  = 1'b1;
        next_neg();
        check(cu_gnt == 8'h00, "R7 gap after release", cu_gnt, 0);
        next_neg();
        check(cu_gnt == 8'h08, "R4 re-requester waits", cu_gnt, 8'h08);
        cu_req = '0;
        cu_flag[3] = 1'b1;
        next_neg();
        cu_flag[3] = 1'b0;
        next_neg();
        check(cu_gnt == '0, "R6 release of unit 3", cu_gnt, 0);

        // pointer at 4: mask 0x81 picks 7; after reset it must pick 0
        cu_req = 8'h81;
        next_neg();
        check(cu_gnt == 8'h80, "R4 search from pointer", cu_gnt, 8'h80);
        rst = 1'b1;
        next_neg();
        check(cu_gnt == '0 && !occ_flag && !mem_en, "R1 reset clears grant",
              {cu_gnt, occ_flag, mem_en}, 0);
        rst = 1'b0;
        next_neg();
        check(cu_gnt == 8'h01, "R1 pointer back to unit 0", cu_gnt, 8'h01);
        cu_req = '0;
        cu_flag[0] = 1'b1;
        next_neg();
        cu_flag[0] = 1'b0;
        repeat (2) next_neg();
        check(cu_gnt == '0, "R2 idle after last release", cu_gnt, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule